// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog driven by a slow-clock enable. A counter advances on each slow tick. When it reaches the selected period it raises a one-cycle reset request for the system, returns to zero and counts again. Software keeps the request from firing by writing a fixed key byte to a restart port. That write only counts inside a window at the end of each period. A write with the wrong byte, or a write before the window opens, raises the reset request at once.

The period, the window size and the low-power behaviour come from option pins. The block takes them while its reset is held and keeps them until the next reset. When the low-power bit is clear, the counter freezes in halt mode, in stop mode, and while the slow oscillator is asked to stop. It then resumes from the value it held. When the low-power bit is set, it keeps counting through all of these. A sticky flag records that a watchdog request happened. Only a status write or a power-on reset clears the flag.

Top module: `win_watchdog`

## Requirements
- R1: The period select `opt_per_sel` picks a period of 2^7, 2^8, 2^9, 2^10, 2^12, 2^14, 2^15 or 2^17 ticks for codes 0 through 7. With a tick on every clock, `wdt_rst_req` first goes high after exactly that many rising edges following reset release.
- R2: At overflow, `wdt_rst_req` is high for one cycle and the counter restarts from zero. The next overflow therefore comes one full period later.
- R3: The window select `opt_win_sel` codes 0, 1, 2 and 3 open the window over the last 25%, 50%, 75% or 100% of the period. For a period P, the window opens at a count of 3P/4, P/2, P/4 or 0.
- R4: Period code 0 together with window code 0 is not allowed. For that pair the window is forced to 100%. Period code 0 with any other window code keeps its normal window.
- R5: A write (`kick_we`) of byte 0xAC while the count is inside the window clears the counter and raises no request.
- R6: A write of any other byte, or of 0xAC while the window is closed, sets `wdt_rst_req` one cycle later and clears the counter.
- R7: With `opt_keep_lp` = 0, the counter holds its value while `halt_mode` or `stop_mode` is high. It resumes from that value afterwards.
- R8: With `opt_keep_lp` = 0, the counter also holds its value while `osc_stop_req` is high.
- R9: With `opt_keep_lp` = 1, the counter keeps counting through halt, stop and oscillator-stop requests.
- R10: The options are captured on every clock while `rst` is high. Changes after release have no effect. Every reset restarts the count from zero.
- R11: `wdt_flag` is set together with every request. It survives `rst` and is cleared by `stat_clr_we` or by `por`. If a new request arrives in the same cycle as a clear, the request wins.
- R12: After reset, `wdt_rst_req` is low. After a power-on reset, `wdt_flag` is also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset; options are captured while high |
| por | input | 1 | Power-on reset; the only reset that clears the sticky flag |
| tick | input | 1 | Slow-clock enable, one pulse per slow tick |
| opt_per_sel | input | 3 | Period select option |
| opt_win_sel | input | 2 | Window size option |
| opt_keep_lp | input | 1 | 1: keep counting in low-power states |
| halt_mode | input | 1 | CPU halt state indication |
| stop_mode | input | 1 | CPU stop state indication |
| osc_stop_req | input | 1 | Software request to stop the slow oscillator |
| kick_we | input | 1 | Write strobe of the restart port |
| kick_data | input | DATA_W | Byte written to the restart port |
| stat_clr_we | input | 1 | Write strobe that clears the sticky flag |
| wdt_rst_req | output | 1 | Registered reset request pulse |
| wdt_flag | output | 1 | Sticky watchdog-request flag |

## Verification
All results are registered. A restart write is judged on the edge where `kick_we` is high, and its request shows after that same edge. An overflow request shows after the P-th counted edge since the last clear. The bench drives inputs on falling edges and counts rising edges between stimulus and check. It samples each result on the falling edge right after the due edge, and also one edge earlier, where the output must still be low. Freeze tests add the held cycles to this count, so a single missed or extra tick moves the request out of the sampled cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Captured option set
  typedef struct packed {
    logic [2:0] per_sel;
    logic [1:0] win_sel;
    logic       keep_lp;
  } wdt_cfg_t;

  // Exponent of the period for each select code (non-uniform steps)
  function automatic int unsigned per_exp(input logic [2:0] sel);
    case (sel)
      3'd0:    return 7;
      3'd1:    return 8;
      3'd2:    return 9;
      3'd3:    return 10;
      3'd4:    return 12;
      3'd5:    return 14;
      3'd6:    return 15;
      default: return 17;
    endcase
  endfunction

endpackage

// File: rtl/wdt_cfg_latch.sv
module wdt_cfg_latch
  import wdt_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       per_sel,
  input  logic [1:0]       win_sel,
  input  logic             keep_lp,
  output logic [2:0]       per_sel_q,
  output logic [1:0]       win_sel_q,
  output logic             keep_lp_q,
  output logic [CNT_W-1:0] last_cnt,
  output logic [CNT_W-1:0] win_start
);

  wdt_cfg_t cfg_q;

  // Options follow the pins while reset is held, then stay frozen
  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '{per_sel: per_sel, win_sel: win_sel, keep_lp: keep_lp};
  end

  assign per_sel_q = cfg_q.per_sel;
  assign win_sel_q = cfg_q.win_sel;
  assign keep_lp_q = cfg_q.keep_lp;

  logic [CNT_W-1:0] quarter;
  logic [CNT_W-1:0] half;
  logic [1:0]       win_eff;

  always_comb begin
    // Modular arithmetic: 2^CNT_W wraps to zero, so minus one gives all ones
    last_cnt = (CNT_W'(1) << per_exp(cfg_q.per_sel)) - CNT_W'(1);
    quarter  = CNT_W'(1) << (per_exp(cfg_q.per_sel) - 2);
    half     = quarter << 1;
    // Disallowed pair falls back to the full window
    win_eff  = ((cfg_q.per_sel == 3'd0) && (cfg_q.win_sel == 2'd0)) ? 2'd3 : cfg_q.win_sel;
    case (win_eff)
      2'd0:    win_start = quarter + half;
      2'd1:    win_start = half;
      2'd2:    win_start = quarter;
      default: win_start = '0;
    endcase
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             hold,
  input  logic             clear,
  input  logic [CNT_W-1:0] last_cnt,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  logic step;

  assign step = tick && !hold;
  assign wrap = step && (cnt == last_cnt) && !clear && !rst;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (clear || wrap) cnt <= '0;
    else if (step)          cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/wdt_kick_ctl.sv
module wdt_kick_ctl #(
  parameter int                CNT_W  = 17,
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY    = 'hAC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              kick_we,
  input  logic [DATA_W-1:0] kick_data,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  win_start,
  input  logic              wrap,
  input  logic              stat_clr,
  output logic              req,
  output logic              flag
);

  logic bad_kick;
  logic fire;

  assign bad_kick = kick_we && ((kick_data != KEY) || (cnt < win_start));
  assign fire     = !rst && (wrap || bad_kick);

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= fire;
  end

  // Sticky flag: only power-on or a software clear removes it; a new event wins
  always_ff @(posedge clk) begin
    if (por)           flag <= 1'b0;
    else if (fire)     flag <= 1'b1;
    else if (stat_clr) flag <= 1'b0;
  end

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int                CNT_W  = 17,
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY    = 'hAC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              tick,
  input  logic [2:0]        opt_per_sel,
  input  logic [1:0]        opt_win_sel,
  input  logic              opt_keep_lp,
  input  logic              halt_mode,
  input  logic              stop_mode,
  input  logic              osc_stop_req,
  input  logic              kick_we,
  input  logic [DATA_W-1:0] kick_data,
  input  logic              stat_clr_we,
  output logic              wdt_rst_req,
  output logic              wdt_flag
);

  logic [2:0]       per_sel_q;
  logic [1:0]       win_sel_q;
  logic             keep_lp_q;
  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] win_start;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             hold;

  wdt_cfg_latch #(.CNT_W(CNT_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .per_sel   (opt_per_sel),
    .win_sel   (opt_win_sel),
    .keep_lp   (opt_keep_lp),
    .per_sel_q (per_sel_q),
    .win_sel_q (win_sel_q),
    .keep_lp_q (keep_lp_q),
    .last_cnt  (last_cnt),
    .win_start (win_start)
  );

  // Freeze in low-power states unless configured to keep running
  assign hold = !keep_lp_q && (halt_mode || stop_mode || osc_stop_req);

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .hold     (hold),
    .clear    (kick_we),
    .last_cnt (last_cnt),
    .cnt      (cnt),
    .wrap     (wrap)
  );

  wdt_kick_ctl #(.CNT_W(CNT_W), .DATA_W(DATA_W), .KEY(KEY)) u_kick (
    .clk       (clk),
    .rst       (rst),
    .por       (por),
    .kick_we   (kick_we),
    .kick_data (kick_data),
    .cnt       (cnt),
    .win_start (win_start),
    .wrap      (wrap),
    .stat_clr  (stat_clr_we),
    .req       (wdt_rst_req),
    .flag      (wdt_flag)
  );

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int                CNT_W  = 17,
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY    = 'hAC
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              halt_mode,
  input logic              stop_mode,
  input logic              osc_stop_req,
  input logic              kick_we,
  input logic [DATA_W-1:0] kick_data,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  last_cnt,
  input logic [CNT_W-1:0]  win_start,
  input logic [2:0]        per_sel_q,
  input logic [1:0]        win_sel_q,
  input logic              keep_lp_q,
  input logic              wdt_rst_req,
  input logic              wdt_flag
);

  // R2
  req_cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_req |-> (cnt == '0));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= last_cnt);

  // R4
  forced_window_chk: assert property (@(posedge clk) disable iff (rst)
    ((per_sel_q == 3'd0) && (win_sel_q == 2'd0)) |-> (win_start == '0));

  // R5
  good_kick_chk: assert property (@(posedge clk) disable iff (rst)
    (kick_we && (kick_data == KEY) && (cnt >= win_start)) |=> (!wdt_rst_req && (cnt == '0)));

  // R6
  bad_kick_chk: assert property (@(posedge clk) disable iff (rst)
    (kick_we && ((kick_data != KEY) || (cnt < win_start))) |=> wdt_rst_req);

  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!keep_lp_q && (halt_mode || stop_mode || osc_stop_req) && !kick_we) |=> $stable(cnt));

  // R9
  keep_running_chk: assert property (@(posedge clk) disable iff (rst)
    (keep_lp_q && tick && !kick_we && (cnt != last_cnt)) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R11
  flag_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_req |-> wdt_flag);

endmodule

bind win_watchdog wdt_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .KEY(KEY)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tick         (tick),
  .halt_mode    (halt_mode),
  .stop_mode    (stop_mode),
  .osc_stop_req (osc_stop_req),
  .kick_we      (kick_we),
  .kick_data    (kick_data),
  .cnt          (cnt),
  .last_cnt     (last_cnt),
  .win_start    (win_start),
  .per_sel_q    (per_sel_q),
  .win_sel_q    (win_sel_q),
  .keep_lp_q    (keep_lp_q),
  .wdt_rst_req  (wdt_rst_req),
  .wdt_flag     (wdt_flag)
);

// File: tb/win_watchdog_bench.sv
`timescale 1ns/1ps
module win_watchdog_bench;

  localparam int LIMIT = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       por = 1'b1;
  logic       tick = 1'b1;
  logic [2:0] opt_per_sel = '0;
  logic [1:0] opt_win_sel = 2'd3;
  logic       opt_keep_lp = 1'b0;
  logic       halt_mode = 1'b0;
  logic       stop_mode = 1'b0;
  logic       osc_stop_req = 1'b0;
  logic       kick_we = 1'b0;
  logic [7:0] kick_data = '0;
  logic       stat_clr_we = 1'b0;
  logic       wdt_rst_req;
  logic       wdt_flag;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  win_watchdog u_win_watchdog (
    .clk(clk), .rst(rst), .por(por), .tick(tick),
    .opt_per_sel(opt_per_sel), .opt_win_sel(opt_win_sel), .opt_keep_lp(opt_keep_lp),
    .halt_mode(halt_mode), .stop_mode(stop_mode), .osc_stop_req(osc_stop_req),
    .kick_we(kick_we), .kick_data(kick_data), .stat_clr_we(stat_clr_we),
    .wdt_rst_req(wdt_rst_req), .wdt_flag(wdt_flag)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog expired: cycles %0d expected below %0d", cyc, LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int period_of(input int code);
    case (code)
      0: return 128;    1: return 256;    2: return 512;    3: return 1024;
      4: return 4096;   5: return 16384;  6: return 32768;  default: return 131072;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input int per, input int win, input bit keep, input bit full);
    @(negedge clk);
    opt_per_sel = 3'(per);
    opt_win_sel = 2'(win);
    opt_keep_lp = keep;
    rst = 1'b1;
    por = full;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    por = 1'b0;
  endtask

  task automatic kick(input logic [7:0] d);
    kick_we = 1'b1;
    kick_data = d;
    @(posedge clk);
    @(negedge clk);
    kick_we = 1'b0;
  endtask

  // Request must be low after n-1 edges and high after n edges
  task automatic expect_req_at(input int n, input string req);
    run(n - 1);
    chk(wdt_rst_req == 1'b0, req, wdt_rst_req, 0);
    run(1);
    chk(wdt_rst_req == 1'b1, req, wdt_rst_req, 1);
  endtask

  task automatic t_reset_state();
    do_reset(0, 3, 0, 1);
    chk(wdt_rst_req == 1'b0, "R12 req after reset", wdt_rst_req, 0);
    chk(wdt_flag == 1'b0, "R12 flag after por", wdt_flag, 0);
  endtask

  task automatic t_periods();
    for (int c = 0; c < 7; c++) begin
      do_reset(c, 3, 0, 0);
      expect_req_at(period_of(c), "R1 period");
      run(1);
      chk(wdt_rst_req == 1'b0, "R2 single-cycle pulse", wdt_rst_req, 0);
      if (c == 0) expect_req_at(127, "R2 restart after wrap");
    end
  endtask

  task automatic t_window();
    for (int w = 0; w < 4; w++) begin
      int start;
      start = 256 - (w + 1) * 64;
      if (start > 0) begin
        do_reset(1, w, 0, 0);
        run(start - 1);
        kick(8'hAC);
        chk(wdt_rst_req == 1'b1, "R3 key before window", wdt_rst_req, 1);
      end
      do_reset(1, w, 0, 0);
      if (start > 0) run(start);
      kick(8'hAC);
      chk(wdt_rst_req == 1'b0, "R3 key at window open", wdt_rst_req, 0);
      expect_req_at(256, "R5 key clears counter");
    end
  endtask

  task automatic t_prohibited();
    do_reset(0, 0, 0, 0);
    run(1);
    kick(8'hAC);
    chk(wdt_rst_req == 1'b0, "R4 forced full window", wdt_rst_req, 0);
    do_reset(0, 1, 0, 0);
    run(1);
    kick(8'hAC);
    chk(wdt_rst_req == 1'b1, "R4 other window untouched", wdt_rst_req, 1);
  endtask

  task automatic t_bad_value();
    do_reset(1, 3, 0, 0);
    run(10);
    kick(8'h55);
    chk(wdt_rst_req == 1'b1, "R6 wrong byte", wdt_rst_req, 1);
    run(1);
    chk(wdt_rst_req == 1'b0, "R6 pulse ends", wdt_rst_req, 0);
    expect_req_at(255, "R6 counter cleared");
  endtask

  task automatic t_freeze();
    do_reset(0, 3, 0, 0);
    run(10);
    halt_mode = 1'b1;
    run(20);
    halt_mode = 1'b0;
    stop_mode = 1'b1;
    run(15);
    stop_mode = 1'b0;
    expect_req_at(118, "R7 halt and stop freeze");
  endtask

  task automatic t_osc_stop();
    do_reset(0, 3, 0, 0);
    run(40);
    osc_stop_req = 1'b1;
    run(200);
    chk(wdt_rst_req == 1'b0, "R8 no overflow while stopped", wdt_rst_req, 0);
    osc_stop_req = 1'b0;
    expect_req_at(88, "R8 resume from held count");
  endtask

  task automatic t_keep_running();
    do_reset(0, 3, 1, 0);
    run(10);
    halt_mode = 1'b1;
    run(20);
    halt_mode = 1'b0;
    osc_stop_req = 1'b1;
    stop_mode = 1'b1;
    run(20);
    osc_stop_req = 1'b0;
    stop_mode = 1'b0;
    expect_req_at(78, "R9 keeps counting");
  endtask

  task automatic t_cfg_locked();
    do_reset(0, 3, 0, 0);
    opt_per_sel = 3'd6;
    opt_win_sel = 2'd0;
    opt_keep_lp = 1'b1;
    run(5);
    kick(8'hAC);
    chk(wdt_rst_req == 1'b0, "R10 window option ignored", wdt_rst_req, 0);
    halt_mode = 1'b1;
    run(10);
    halt_mode = 1'b0;
    expect_req_at(128, "R10 period option ignored");
    run(30);
    do_reset(0, 3, 0, 0);
    expect_req_at(128, "R10 count restarts at reset");
  endtask

  task automatic t_sticky();
    do_reset(0, 3, 0, 1);
    chk(wdt_flag == 1'b0, "R11 cleared by por", wdt_flag, 0);
    run(128);
    chk(wdt_flag == 1'b1, "R11 set with request", wdt_flag, 1);
    do_reset(0, 3, 0, 0);
    chk(wdt_flag == 1'b1, "R11 survives rst", wdt_flag, 1);
    stat_clr_we = 1'b1;
    run(1);
    stat_clr_we = 1'b0;
    chk(wdt_flag == 1'b0, "R11 status write clears", wdt_flag, 0);
    stat_clr_we = 1'b1;
    kick(8'h00);
    stat_clr_we = 1'b0;
    chk(wdt_flag == 1'b1, "R11 request beats clear", wdt_flag, 1);
    do_reset(0, 3, 0, 1);
    chk(wdt_flag == 1'b0, "R11 por clears again", wdt_flag, 0);
  endtask

  initial begin
    t_reset_state();
    t_periods();
    t_window();
    t_prohibited();
    t_bad_value();
    t_freeze();
    t_osc_stop();
    t_keep_running();
    t_cfg_locked();
    t_sticky();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule